// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block sits beside the first bank of a general-purpose I/O controller. It watches up to 32 already-synchronised input lines and decides, line by line, whether each one is asking for service. Each line has a type bit and a polarity bit. Together they give four trigger kinds: high level, low level, rising edge and falling edge. Level requests follow the pin as long as it is active. Edge requests are held in a per-line latch until software acknowledges them.

Software programs the block through a simple register port: a write strobe, a byte address, a write word and a combinational read word. An enable bit arms a line. A mask bit hides an armed line from the interrupt output but not from the raw view. Two read-only views show pending lines, one before masking and one after. The interrupt output is a single registered OR of all unmasked pending lines. Software can service any set status bit in any order, and writes ones to the acknowledge register to drop latched edges.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration register, the raw view, the status view and `irqOut` are zero.
- R2: Enable (0x30), mask (0x34), type (0x38) and polarity (0x3C) read back what was written, limited to the implemented lines. Writes to status (0x40) and raw (0x44) have no effect. The acknowledge register (0x4C) and any unmapped address read as zero.
- R3: A line with type 0 and polarity 1 is pending exactly while its pin is 1, and the raw view follows the pin combinationally.
- R4: A line with type 0 and polarity 0 is pending exactly while its pin is 0.
- R5: A line with type 1 and polarity 1 latches a request when its pin is 0 on one clock edge and 1 on the next. The request is held after the pin falls. A 1-to-0 transition sets nothing.
- R6: A line with type 1 and polarity 0 latches a request on a 1-to-0 transition, holds it, and ignores 0-to-1 transitions.
- R7: Writing 1 to bit n of the acknowledge register clears line n's latched edge. Bits written 0 change nothing. A new edge arriving in the same cycle as the clear wins, and the request stays set.
- R8: A line whose enable bit is 0 is never pending. Clearing the enable bit discards a latched edge, so re-enabling with a steady pin shows no request.
- R9: Status (0x40) equals raw (0x44) with the masked lines removed. Masking never alters the raw view.
- R10: `irqOut` is 1 exactly one clock after the status view has any bit set, and 0 one clock after it is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_LINES | Synchronised line values |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data, combinational from `regAddr` |
| irqOut | output | 1 | Combined registered interrupt request |

## Verification
Every line of an 8-line build is swept through all four trigger kinds. Each pass checks that exactly that line's bit appears, which separates per-line wiring faults from mode-decoding faults. Edge modes are driven with both transition directions, with partial and full acknowledge words, and with an edge that coincides with an acknowledge. This separates a latch from a pin follower and tests set-over-clear priority. A multi-line pin pattern under a partial mask separates masked status from the raw view. A single-edge timing probe confirms the one-cycle delay between a level change and `irqOut`.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] OFF_ENABLE = 8'h30;
  localparam logic [7:0] OFF_MASK   = 8'h34;
  localparam logic [7:0] OFF_TYPE   = 8'h38;
  localparam logic [7:0] OFF_POL    = 8'h3C;
  localparam logic [7:0] OFF_STATUS = 8'h40;
  localparam logic [7:0] OFF_RAW    = 8'h44;
  localparam logic [7:0] OFF_ACK    = 8'h4C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ENABLE,
    RD_MASK,
    RD_TYPE,
    RD_POL,
    RD_STATUS,
    RD_RAW
  } rdSel_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrMask;
    logic   wrType;
    logic   wrPol;
    logic   wrAck;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);

  // Address decode: one write strobe per writable register, one read select.
  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    case (regAddr)
      ADDR_W'(OFF_ENABLE): begin strobes.wrEnable = regWrEn; strobes.rdSel = RD_ENABLE; end
      ADDR_W'(OFF_MASK):   begin strobes.wrMask   = regWrEn; strobes.rdSel = RD_MASK;   end
      ADDR_W'(OFF_TYPE):   begin strobes.wrType   = regWrEn; strobes.rdSel = RD_TYPE;   end
      ADDR_W'(OFF_POL):    begin strobes.wrPol    = regWrEn; strobes.rdSel = RD_POL;    end
      ADDR_W'(OFF_STATUS): strobes.rdSel = RD_STATUS;
      ADDR_W'(OFF_RAW):    strobes.rdSel = RD_RAW;
      ADDR_W'(OFF_ACK):    strobes.wrAck = regWrEn;
      default:             strobes.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  input  logic enable,
  input  logic edgeMode,
  input  logic polHigh,
  input  logic ackClr,
  output logic rawOut
);

  logic pinPrev;
  logic edgeLatch;
  logic edgeSeen;
  logic levelActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pin;
  end

  assign edgeSeen    = polHigh ? (pin & ~pinPrev) : (~pin & pinPrev);
  assign levelActive = polHigh ? pin : ~pin;

  // A new edge takes priority over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   edgeLatch <= 1'b0;
    else if (!enable || !edgeMode) edgeLatch <= 1'b0;
    else if (edgeSeen)           edgeLatch <= 1'b1;
    else if (ackClr)             edgeLatch <= 1'b0;
  end

  assign rawOut = enable & (edgeMode ? edgeLatch : levelActive);

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic [NUM_LINES-1:0] wdLines,
  input  ctrlStrobes_t         strobes,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut,
  output logic [NUM_LINES-1:0] enableVec,
  output logic [NUM_LINES-1:0] maskVec,
  output logic [NUM_LINES-1:0] typeVec,
  output logic [NUM_LINES-1:0] polVec,
  output logic [NUM_LINES-1:0] rawVec,
  output logic [NUM_LINES-1:0] statusVec
);

  logic [NUM_LINES-1:0] ackVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableVec <= '0;
      maskVec   <= '0;
      typeVec   <= '0;
      polVec    <= '0;
    end else begin
      if (strobes.wrEnable) enableVec <= wdLines;
      if (strobes.wrMask)   maskVec   <= wdLines;
      if (strobes.wrType)   typeVec   <= wdLines;
      if (strobes.wrPol)    polVec    <= wdLines;
    end
  end

  assign ackVec = strobes.wrAck ? wdLines : '0;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    gpio_irq_line u_line (
      .clk      (clk),
      .rstN     (rstN),
      .pin      (pinIn[g]),
      .enable   (enableVec[g]),
      .edgeMode (typeVec[g]),
      .polHigh  (polVec[g]),
      .ackClr   (ackVec[g]),
      .rawOut   (rawVec[g])
    );
  end

  assign statusVec = rawVec & ~maskVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |statusVec;
  end

  always_comb begin
    case (strobes.rdSel)
      RD_ENABLE: regRdata = DATA_W'(enableVec);
      RD_MASK:   regRdata = DATA_W'(maskVec);
      RD_TYPE:   regRdata = DATA_W'(typeVec);
      RD_POL:    regRdata = DATA_W'(polVec);
      RD_STATUS: regRdata = DATA_W'(statusVec);
      RD_RAW:    regRdata = DATA_W'(rawVec);
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut
);

  ctrlStrobes_t         strobes;
  logic [NUM_LINES-1:0] enableVec;
  logic [NUM_LINES-1:0] maskVec;
  logic [NUM_LINES-1:0] typeVec;
  logic [NUM_LINES-1:0] polVec;
  logic [NUM_LINES-1:0] rawVec;
  logic [NUM_LINES-1:0] statusVec;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  gpio_irq_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .wdLines   (regWdata[NUM_LINES-1:0]),
    .strobes   (strobes),
    .regRdata  (regRdata),
    .irqOut    (irqOut),
    .enableVec (enableVec),
    .maskVec   (maskVec),
    .typeVec   (typeVec),
    .polVec    (polVec),
    .rawVec    (rawVec),
    .statusVec (statusVec)
  );

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] pinIn,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] enableVec,
  input logic [NUM_LINES-1:0] maskVec,
  input logic [NUM_LINES-1:0] typeVec,
  input logic [NUM_LINES-1:0] polVec,
  input logic [NUM_LINES-1:0] rawVec,
  input logic [NUM_LINES-1:0] statusVec
);

  assert_level_high_tracks_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((rawVec ^ pinIn) & enableVec & ~typeVec & polVec) == '0);

  assert_level_low_tracks_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((rawVec ^ ~pinIn) & enableVec & ~typeVec & ~polVec) == '0);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rawVec & ~enableVec) == '0);

  assert_masked_hidden_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec & maskVec) == '0);

  assert_irq_one_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|statusVec)));

endmodule

bind gpio_irq_detect gpio_irq_checker #(.NUM_LINES(NUM_LINES)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .pinIn     (pinIn),
  .irqOut    (irqOut),
  .enableVec (enableVec),
  .maskVec   (maskVec),
  .typeVec   (typeVec),
  .polVec    (polVec),
  .rawVec    (rawVec),
  .statusVec (statusVec)
);

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
  import gpio_irq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int DW = 32;
  localparam int AW = 8;

  logic             clk;
  logic             rstN;
  logic [LINES-1:0] pinIn;
  logic             regWrEn;
  logic [AW-1:0]    regAddr;
  logic [DW-1:0]    regWdata;
  logic [DW-1:0]    regRdata;
  logic             irqOut;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  gpio_irq_detect #(.NUM_LINES(LINES), .DATA_W(DW), .ADDR_W(AW)) u_gpio_irq_detect (
    .clk, .rstN, .pinIn, .regWrEn, .regAddr, .regWdata, .regRdata, .irqOut
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    string tag;
    rstN = 1'b0; pinIn = '0; regWrEn = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) tick();
    check("R1 irqOut in reset", {31'b0, irqOut}, 32'h0);
    rstN = 1'b1;
    tick();
    rdReg(OFF_ENABLE, rd); check("R1 enable", rd, 0);
    rdReg(OFF_MASK, rd);   check("R1 mask", rd, 0);
    rdReg(OFF_TYPE, rd);   check("R1 type", rd, 0);
    rdReg(OFF_POL, rd);    check("R1 polarity", rd, 0);
    rdReg(OFF_STATUS, rd); check("R1 status", rd, 0);
    rdReg(OFF_RAW, rd);    check("R1 raw", rd, 0);
    check("R1 irqOut", {31'b0, irqOut}, 0);

    // R2 register map
    wrReg(OFF_MASK, 32'hFFFF_FFA5); rdReg(OFF_MASK, rd); check("R2 mask readback", rd, 32'hA5);
    wrReg(OFF_TYPE, 32'h3C);        rdReg(OFF_TYPE, rd); check("R2 type readback", rd, 32'h3C);
    wrReg(OFF_POL, 32'hC3);         rdReg(OFF_POL, rd);  check("R2 polarity readback", rd, 32'hC3);
    wrReg(OFF_ENABLE, 32'h5A);      rdReg(OFF_ENABLE, rd); check("R2 enable readback", rd, 32'h5A);
    wrReg(OFF_RAW, 32'hFF);         rdReg(OFF_RAW, rd);  check("R2 raw write ignored", rd, 0);
    wrReg(OFF_STATUS, 32'hFF);      rdReg(OFF_STATUS, rd); check("R2 status write ignored", rd, 0);
    rdReg(OFF_ENABLE, rd); check("R2 enable unaliased", rd, 32'h5A);
    rdReg(OFF_ACK, rd);    check("R2 ack reads zero", rd, 0);
    rdReg(8'h00, rd);      check("R2 unmapped reads zero", rd, 0);
    wrReg(OFF_ENABLE, 0); wrReg(OFF_MASK, 0); wrReg(OFF_TYPE, 0); wrReg(OFF_POL, 0);

    // Sweep: every line through every trigger kind
    for (int i = 0; i < LINES; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic edgeM, polH;
        logic [LINES-1:0] act, inact;
        logic [31:0] bitI;
        edgeM = m[1]; polH = m[0];
        bitI  = 32'(1) << i;
        act   = polH ? LINES'(bitI) : '0;
        inact = polH ? '0 : LINES'(bitI);
        tag   = edgeM ? (polH ? "R5" : "R6") : (polH ? "R3" : "R4");
        pinIn = inact; tick(); tick();
        wrReg(OFF_TYPE, edgeM ? bitI : 0);
        wrReg(OFF_POL, polH ? bitI : 0);
        wrReg(OFF_ENABLE, bitI);
        rdReg(OFF_RAW, rd); check({tag, " idle raw"}, rd, 0);
        pinIn = act; tick(); tick();
        rdReg(OFF_RAW, rd);    check({tag, " active raw"}, rd, bitI);
        rdReg(OFF_STATUS, rd); check({tag, " active status"}, rd, bitI);
        check("R10 irq raised", {31'b0, irqOut}, 1);
        if (edgeM) begin
          wrReg(OFF_ACK, ~bitI);
          rdReg(OFF_RAW, rd); check("R7 zero bits keep latch", rd, bitI);
          wrReg(OFF_ACK, bitI);
          rdReg(OFF_RAW, rd); check("R7 ack clears latch", rd, 0);
          tick(); check("R10 irq dropped", {31'b0, irqOut}, 0);
          pinIn = inact; tick(); tick();
          rdReg(OFF_RAW, rd); check({tag, " opposite edge ignored"}, rd, 0);
          pinIn = act; tick();
          pinIn = inact; tick(); tick();
          rdReg(OFF_RAW, rd); check({tag, " latch held"}, rd, bitI);
        end else begin
          pinIn = inact; tick(); tick();
          rdReg(OFF_RAW, rd); check({tag, " level released"}, rd, 0);
          pinIn = act; tick();
        end
        wrReg(OFF_MASK, bitI);
        rdReg(OFF_RAW, rd);    check("R9 mask keeps raw", rd, bitI);
        rdReg(OFF_STATUS, rd); check("R9 mask hides status", rd, 0);
        tick(); check("R9 masked irq low", {31'b0, irqOut}, 0);
        wrReg(OFF_MASK, 0);
        rdReg(OFF_STATUS, rd); check("R9 unmask restores", rd, bitI);
        wrReg(OFF_ENABLE, 0);
        rdReg(OFF_RAW, rd); check("R8 disabled raw", rd, 0);
        tick(); check("R8 disabled irq", {31'b0, irqOut}, 0);
        wrReg(OFF_ENABLE, bitI);
        rdReg(OFF_RAW, rd); check("R8 reenable", rd, edgeM ? 0 : bitI);
        wrReg(OFF_ENABLE, 0); pinIn = '0;
        wrReg(OFF_TYPE, 0); wrReg(OFF_POL, 0);
      end
    end

    // R7 edge and acknowledge in the same cycle
    wrReg(OFF_TYPE, 1); wrReg(OFF_POL, 1); wrReg(OFF_ENABLE, 1);
    pinIn = 8'h01; tick(); tick();
    pinIn = 8'h00; tick(); tick();
    rdReg(OFF_RAW, rd); check("R7 latched before collision", rd, 1);
    pinIn = 8'h01; regAddr = OFF_ACK; regWdata = 1; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; regWdata = 0;
    rdReg(OFF_RAW, rd); check("R7 edge wins over ack", rd, 1);
    wrReg(OFF_ENABLE, 0); pinIn = '0; wrReg(OFF_TYPE, 0); wrReg(OFF_POL, 0);

    // R10 exact timing, line 0 level high
    wrReg(OFF_POL, 1); wrReg(OFF_ENABLE, 1);
    pinIn = 8'h01;
    rdReg(OFF_RAW, rd); check("R3 raw follows pin at once", rd, 1);
    check("R10 irq not yet", {31'b0, irqOut}, 0);
    tick(); check("R10 irq after one clock", {31'b0, irqOut}, 1);
    pinIn = 8'h00; #1;
    check("R10 irq still held", {31'b0, irqOut}, 1);
    tick(); check("R10 irq falls after one clock", {31'b0, irqOut}, 0);

    // R9 multi-line pattern with partial mask
    wrReg(OFF_POL, 32'hFF); wrReg(OFF_ENABLE, 32'hFF);
    pinIn = 8'hA5; wrReg(OFF_MASK, 32'h0F);
    rdReg(OFF_RAW, rd);    check("R9 multi raw", rd, 32'hA5);
    rdReg(OFF_STATUS, rd); check("R9 multi status", rd, 32'hA0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule